// File: doc/BRIEF.md
# Converter Channel Trigger and DMA Request Controller

This block governs a single data channel that feeds a digital-to-analog converter. Software places a sample in a holding register. The block copies it to the output register when a conversion trigger fires. The trigger is either a software command or the rising edge of one of seven external trigger lines, chosen by a select field. The select field can only change while the channel is switched off.

An external trigger can also ask a DMA engine for the next sample. Only one request can be outstanding at a time. If a second external trigger arrives before the engine acknowledges the first, the block records a sticky underrun error. It then stops requesting until software recovers, and it can raise an interrupt for the error. An optional noise mode adds the value of a 12-bit LFSR to the holding value and saturates the sum. This gives a pseudonoise waveform of adjustable amplitude.

Software reaches four registers through a simple single-cycle write strobe and a combinational read port. The register at address 0 is the control register. Address 1 holds the sample, address 2 is the software trigger, and address 3 is the status register.

Top module: `dac_trig_ctrl`

## Requirements
- R1: After reset, `dout`, `dma_req` and `irq` are 0, and a read of the control register (address 0) or the status register (address 3) returns 0.
- R2: While the channel is enabled (control bit 0) and the select field (control bits 3:1) holds a value from 0 to 6, a rising edge on the `trig_in` line with that index loads `dout` from the holding register (address 1, bits 11:0) at the clock edge where the rise is first seen. A line held high does not load again.
- R3: With select value 7, writing 1 to bit 0 of address 2 sets a pending bit, which reads back as bit 0 of address 2. On the next clock edge `dout` is loaded and the pending bit clears. External lines have no effect while select value 7 is chosen.
- R4: While the channel enable bit is 1, a write to the control register leaves the select field unchanged.
- R5: With DMA enable (control bit 4) set, an external trigger raises `dma_req` at the same edge that loads `dout`. The request stays high until `dma_ack` is seen high at a clock edge. A software trigger never raises `dma_req`.
- R6: An external trigger that arrives while a request is outstanding, with `dma_ack` low in that cycle, sets the underrun flag (status bit 0) and drops `dma_req`. In that case `dout` is not loaded. A trigger that coincides with `dma_ack` starts a new request instead, and no underrun is recorded.
- R7: After an underrun, external triggers still load `dout` but raise no request. Requests resume only after the flag has been cleared and DMA enable has been written to 0 and then to 1.
- R8: Writing 1 to status bit 0 clears the underrun flag. Writing 0 leaves it set.
- R9: `irq` is high exactly while the underrun flag is set and the interrupt enable bit (control bit 5) is 1.
- R10: With wave mode (control bits 7:6) equal to 01, a trigger loads `dout` with the holding value plus the LFSR value, saturated to 0xFFF. The LFSR starts at 0xAAA. It advances three clock cycles after each trigger by shifting toward the MSB, and the new bit 0 is the XOR of bits 11, 5, 3 and 0.
- R11: The LFSR returns to 0xAAA whenever the channel is disabled or the wave mode is not 01. Triggers of either kind are ignored while the channel is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Register address for both writes and reads |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| trig_in | input | 7 | External trigger lines, synchronous to `clk` |
| dma_req | output | 1 | DMA request for the next sample |
| dma_ack | input | 1 | DMA acknowledge |
| dout | output | 12 | Output data register feeding the converter |
| irq | output | 1 | Underrun interrupt |

## Verification
The delicate coincidence is an external trigger landing in the same clock cycle as the DMA acknowledge for the previous request. The bench drives both high in one cycle. It then expects `dma_req` to still be high and the status register to show no underrun. This separates the pair from the case where the acknowledge arrives a cycle too late, which must set the flag and suppress the load. A second overlap is a write to the control register in the cycle the channel is enabled: the select field must keep its old value.

// File: rtl/dac_trig_pkg.sv
package dac_trig_pkg;

  typedef enum logic [1:0] {
    WAVE_OFF   = 2'b00,
    WAVE_NOISE = 2'b01,
    WAVE_RSV2  = 2'b10,
    WAVE_RSV3  = 2'b11
  } wave_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_HOLD = 2'd1;
  localparam logic [1:0] ADDR_SWTR = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_SEL_LSB = 1;
  localparam int CTRL_DMA_BIT = 4;
  localparam int CTRL_IE_BIT  = 5;
  localparam int CTRL_WV_LSB  = 6;

endpackage

// File: rtl/dac_trig_sel.sv
module dac_trig_sel #(
  parameter int NUM_EXT = 7,
  parameter int SEL_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chan_en,
  input  logic [SEL_W-1:0]   trig_sel,
  input  logic [NUM_EXT-1:0] trig_in,
  input  logic               sw_set,
  output logic               ext_evt,
  output logic               sw_evt,
  output logic               sw_pend
);
  localparam logic [SEL_W-1:0] SW_SEL = '1;

  logic sel_lvl, lvl_q, pend_d;
  logic is_sw;

  assign is_sw = (trig_sel == SW_SEL);

  always_comb begin
    sel_lvl = 1'b0;
    for (int i = 0; i < NUM_EXT; i++) begin
      if (trig_sel == SEL_W'(i)) sel_lvl = trig_in[i];
    end
  end

  assign ext_evt = chan_en & ~is_sw & sel_lvl & ~lvl_q;
  assign sw_evt  = chan_en & sw_pend;

  always_comb begin
    if (!chan_en)     pend_d = 1'b0;
    else if (sw_pend) pend_d = 1'b0;
    else              pend_d = sw_set & is_sw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= 1'b0;
      sw_pend <= 1'b0;
    end else begin
      lvl_q   <= sel_lvl;
      sw_pend <= pend_d;
    end
  end
endmodule

// File: rtl/dac_dma_ctl.sv
module dac_dma_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_en,
  input  logic ext_evt,
  input  logic dma_ack,
  input  logic flag_clr,
  output logic dma_req,
  output logic udr_flag,
  output logic udr_evt
);
  logic lock_q, lock_d, req_d, flag_d;

  assign udr_evt = ext_evt & dma_en & ~lock_q & dma_req & ~dma_ack;

  always_comb begin
    if (!dma_en || lock_q || udr_evt) req_d = 1'b0;
    else if (ext_evt)                 req_d = 1'b1;
    else if (dma_ack)                 req_d = 1'b0;
    else                              req_d = dma_req;

    if (udr_evt)       flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
    else               flag_d = udr_flag;

    if (udr_evt)                 lock_d = 1'b1;
    else if (!dma_en && !udr_flag) lock_d = 1'b0;
    else                         lock_d = lock_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_req  <= 1'b0;
      udr_flag <= 1'b0;
      lock_q   <= 1'b0;
    end else begin
      dma_req  <= req_d;
      udr_flag <= flag_d;
      lock_q   <= lock_d;
    end
  end
endmodule

// File: rtl/dac_noise_lfsr.sv
module dac_noise_lfsr #(
  parameter int           W     = 12,
  parameter logic [W-1:0] SEED  = 12'hAAA,
  parameter logic [W-1:0] TAPS  = 12'h829,
  parameter int           DLY   = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         seed_ld,
  input  logic         trig_evt,
  output logic [W-1:0] lfsr
);
  logic [DLY-1:0] pipe_q, pipe_d;
  logic [W-1:0]   lfsr_d;
  logic           step;

  generate
    if (DLY == 1) begin : g_dly1
      always_comb pipe_d = seed_ld ? 1'b0 : trig_evt;
    end else begin : g_dlyn
      always_comb pipe_d = seed_ld ? '0 : {pipe_q[DLY-2:0], trig_evt};
    end
  endgenerate

  assign step = pipe_q[DLY-1];

  always_comb begin
    if (seed_ld)   lfsr_d = SEED;
    else if (step) lfsr_d = {lfsr[W-2:0], ^(lfsr & TAPS)};
    else           lfsr_d = lfsr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
      lfsr   <= SEED;
    end else begin
      pipe_q <= pipe_d;
      lfsr   <= lfsr_d;
    end
  end
endmodule

// File: rtl/dac_trig_ctrl.sv
module dac_trig_ctrl
  import dac_trig_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int NUM_EXT = 7,
  parameter int REG_W   = 16,
  parameter int NOISE_DLY = 3,
  parameter logic [DATA_W-1:0] LFSR_SEED = 12'hAAA,
  parameter logic [DATA_W-1:0] LFSR_TAPS = 12'h829
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic [NUM_EXT-1:0] trig_in,
  output logic               dma_req,
  input  logic               dma_ack,
  output logic [DATA_W-1:0]  dout,
  output logic               irq
);
  localparam int SEL_W = $clog2(NUM_EXT + 1);

  logic              chan_en_q, dma_en_q, ie_q;
  logic [SEL_W-1:0]  trig_sel_q;
  wave_e             wave_q;
  logic [DATA_W-1:0] hold_q;

  logic              chan_en_d, dma_en_d, ie_d;
  logic [SEL_W-1:0]  trig_sel_d;
  wave_e             wave_d;
  logic [DATA_W-1:0] hold_d, dout_d;

  logic wr_ctrl, wr_hold, sw_set, flag_clr;
  logic ext_evt, sw_evt, sw_pend, udr_flag, udr_evt;
  logic noise_on, load;
  logic [DATA_W-1:0] lfsr;
  logic [DATA_W:0]   sum;

  assign wr_ctrl  = reg_wr & (reg_addr == ADDR_CTRL);
  assign wr_hold  = reg_wr & (reg_addr == ADDR_HOLD);
  assign sw_set   = reg_wr & (reg_addr == ADDR_SWTR) & reg_wdata[0];
  assign flag_clr = reg_wr & (reg_addr == ADDR_STAT) & reg_wdata[0];

  dac_trig_sel #(.NUM_EXT(NUM_EXT), .SEL_W(SEL_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en_q), .trig_sel(trig_sel_q),
    .trig_in(trig_in), .sw_set(sw_set), .ext_evt(ext_evt),
    .sw_evt(sw_evt), .sw_pend(sw_pend)
  );

  dac_dma_ctl u_dma (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en_q), .ext_evt(ext_evt),
    .dma_ack(dma_ack), .flag_clr(flag_clr), .dma_req(dma_req),
    .udr_flag(udr_flag), .udr_evt(udr_evt)
  );

  assign noise_on = (wave_q == WAVE_NOISE);

  dac_noise_lfsr #(.W(DATA_W), .SEED(LFSR_SEED), .TAPS(LFSR_TAPS), .DLY(NOISE_DLY)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .seed_ld(~chan_en_q | ~noise_on),
    .trig_evt(ext_evt | sw_evt), .lfsr(lfsr)
  );

  // Register file next state; the select field is frozen while enabled.
  always_comb begin
    chan_en_d  = chan_en_q;
    trig_sel_d = trig_sel_q;
    dma_en_d   = dma_en_q;
    ie_d       = ie_q;
    wave_d     = wave_q;
    hold_d     = hold_q;
    if (wr_ctrl) begin
      chan_en_d = reg_wdata[CTRL_EN_BIT];
      if (!chan_en_q) trig_sel_d = reg_wdata[CTRL_SEL_LSB +: SEL_W];
      dma_en_d  = reg_wdata[CTRL_DMA_BIT];
      ie_d      = reg_wdata[CTRL_IE_BIT];
      wave_d    = wave_e'(reg_wdata[CTRL_WV_LSB +: 2]);
    end
    if (wr_hold) hold_d = reg_wdata[DATA_W-1:0];
  end

  // Output register: load on a software trigger or a non-underrun external trigger.
  assign sum  = {1'b0, hold_q} + {1'b0, lfsr};
  assign load = sw_evt | (ext_evt & ~udr_evt);

  always_comb begin
    dout_d = dout;
    if (load) begin
      if (!noise_on)    dout_d = hold_q;
      else if (sum[DATA_W]) dout_d = '1;
      else              dout_d = sum[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_en_q  <= 1'b0;
      trig_sel_q <= '0;
      dma_en_q   <= 1'b0;
      ie_q       <= 1'b0;
      wave_q     <= WAVE_OFF;
      hold_q     <= '0;
      dout       <= '0;
    end else begin
      chan_en_q  <= chan_en_d;
      trig_sel_q <= trig_sel_d;
      dma_en_q   <= dma_en_d;
      ie_q       <= ie_d;
      wave_q     <= wave_d;
      hold_q     <= hold_d;
      dout       <= dout_d;
    end
  end

  assign irq = udr_flag & ie_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_CTRL: begin
        reg_rdata[CTRL_EN_BIT]             = chan_en_q;
        reg_rdata[CTRL_SEL_LSB +: SEL_W]   = trig_sel_q;
        reg_rdata[CTRL_DMA_BIT]            = dma_en_q;
        reg_rdata[CTRL_IE_BIT]             = ie_q;
        reg_rdata[CTRL_WV_LSB +: 2]        = wave_q;
      end
      ADDR_HOLD: reg_rdata[DATA_W-1:0] = hold_q;
      ADDR_SWTR: reg_rdata[0] = sw_pend;
      default:   reg_rdata[0] = udr_flag;
    endcase
  end
endmodule

// File: rtl/dac_trig_ctrl_chk.sv
module dac_trig_ctrl_chk #(
  parameter int SEL_W = 3,
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [REG_W-1:0] reg_wdata,
  input logic             dma_req,
  input logic             dma_ack,
  input logic             irq,
  input logic             chan_en,
  input logic [SEL_W-1:0] trig_sel,
  input logic             dma_en,
  input logic             udr_flag
);
  localparam logic [SEL_W-1:0] SW_SEL = '1;

  a_r4_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en |=> $stable(trig_sel));

  a_r5_req_needs_dma_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req) |-> dma_en);

  a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_ack && dma_en) |=> (dma_req || udr_flag));

  a_r3_sw_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req) |-> (trig_sel != SW_SEL));

  a_r6_underrun_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(udr_flag) |-> !dma_req);

  a_r7_no_req_while_flag: assert property (@(posedge clk) disable iff (!rst_n)
    udr_flag |-> !$rose(dma_req));

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (udr_flag && !(reg_wr && reg_addr == 2'd3 && reg_wdata[0])) |=> udr_flag);

  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> udr_flag);
endmodule

bind dac_trig_ctrl dac_trig_ctrl_chk #(.SEL_W(SEL_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .dma_req(dma_req), .dma_ack(dma_ack), .irq(irq),
  .chan_en(chan_en_q), .trig_sel(trig_sel_q), .dma_en(dma_en_q),
  .udr_flag(udr_flag)
);

// File: tb/tb_dac_trig_ctrl.sv
module tb_dac_trig_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [6:0]  trig_in;
  logic        dma_req;
  logic        dma_ack;
  logic [11:0] dout;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  dac_trig_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_in(trig_in),
    .dma_req(dma_req), .dma_ack(dma_ack), .dout(dout), .irq(irq)
  );

  // {select, holding value, expected dout}
  localparam logic [26:0] VEC [6] = '{
    {3'd0, 12'h123, 12'h123},
    {3'd3, 12'h5A5, 12'h5A5},
    {3'd6, 12'hFFF, 12'hFFF},
    {3'd7, 12'h321, 12'h321},
    {3'd2, 12'h000, 12'h000},
    {3'd7, 12'hABC, 12'hABC}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    trig_in[idx] = 1'b1;
    @(negedge clk);
    trig_in[idx] = 1'b0;
  endtask

  task automatic sw_fire();
    wr(2'd2, 16'h0001);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [11:0] lstep(input logic [11:0] x);
    return {x[10:0], x[11] ^ x[5] ^ x[3] ^ x[0]};
  endfunction

  function automatic logic [11:0] sat(input logic [11:0] a, input logic [11:0] b);
    logic [12:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[12] ? 12'hFFF : s[11:0];
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] r;
    logic [11:0] model;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    trig_in = '0; dma_ack = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    chk("R1 dout", {4'h0, dout}, 16'h0);
    chk("R1 dma_req", {15'h0, dma_req}, 16'h0);
    chk("R1 irq", {15'h0, irq}, 16'h0);
    rd(2'd0, r); chk("R1 ctrl", r, 16'h0);
    rd(2'd3, r); chk("R1 status", r, 16'h0);

    // Vector table: R2 external, R3 software transfers
    for (int i = 0; i < 6; i++) begin
      logic [2:0]  s;
      logic [11:0] h, e;
      {s, h, e} = VEC[i];
      wr(2'd0, {12'h0, s, 1'b0});
      wr(2'd0, {12'h0, s, 1'b1});
      wr(2'd1, {4'h0, h});
      if (s == 3'd7) sw_fire();
      else begin pulse(int'(s)); @(negedge clk); end
      chk(s == 3'd7 ? "R3 sw load" : "R2 ext load", {4'h0, dout}, {4'h0, e});
    end

    // R2 level held does not retrigger
    wr(2'd0, 16'h0000); wr(2'd0, 16'h0003);
    wr(2'd1, 16'h0111);
    @(negedge clk); trig_in[1] = 1'b1;
    @(negedge clk);
    chk("R2 rise load", {4'h0, dout}, 16'h0111);
    wr(2'd1, 16'h0222);
    idle(3);
    chk("R2 held level", {4'h0, dout}, 16'h0111);
    trig_in[1] = 1'b0;

    // R11 disabled channel ignores triggers
    wr(2'd0, 16'h0002);
    wr(2'd1, 16'h0333);
    pulse(1); idle(1);
    chk("R11 ext ignored when off", {4'h0, dout}, 16'h0111);
    wr(2'd2, 16'h0001); idle(2);
    chk("R11 sw ignored when off", {4'h0, dout}, 16'h0111);

    // R3 software path: pending bit, ext lines ignored, no DMA (R5)
    wr(2'd0, 16'h001E);
    wr(2'd0, 16'h001F);
    wr(2'd1, 16'h0444);
    for (int k = 0; k < 7; k++) pulse(k);
    idle(1);
    chk("R3 ext ignored in sw select", {4'h0, dout}, 16'h0111);
    wr(2'd2, 16'h0001);
    rd(2'd2, r); chk("R3 pending set", r, 16'h0001);
    @(negedge clk);
    chk("R3 one-cycle load", {4'h0, dout}, 16'h0444);
    rd(2'd2, r); chk("R3 pending cleared", r, 16'h0000);
    chk("R5 sw raises no request", {15'h0, dma_req}, 16'h0);

    // R4 select frozen while enabled
    wr(2'd0, 16'h0005);
    rd(2'd0, r); chk("R4 select kept", {13'h0, r[3:1]}, 16'h0007);

    // R5 DMA request and acknowledge
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h0011);
    wr(2'd1, 16'h0050);
    pulse(0);
    chk("R5 req raised", {15'h0, dma_req}, 16'h1);
    chk("R5 load with req", {4'h0, dout}, 16'h0050);
    idle(2);
    chk("R5 req held", {15'h0, dma_req}, 16'h1);
    @(negedge clk); dma_ack = 1'b1;
    @(negedge clk); dma_ack = 1'b0;
    chk("R5 req cleared by ack", {15'h0, dma_req}, 16'h0);

    // R6 trigger coinciding with ack
    pulse(0);
    @(negedge clk); trig_in[0] = 1'b1; dma_ack = 1'b1;
    @(negedge clk); trig_in[0] = 1'b0; dma_ack = 1'b0;
    chk("R6 coincide keeps req", {15'h0, dma_req}, 16'h1);
    rd(2'd3, r); chk("R6 coincide no underrun", r, 16'h0);
    @(negedge clk); dma_ack = 1'b1;
    @(negedge clk); dma_ack = 1'b0;

    // R6 underrun
    wr(2'd1, 16'h0060);
    pulse(0);
    chk("R6 first load", {4'h0, dout}, 16'h0060);
    wr(2'd1, 16'h0070);
    pulse(0);
    rd(2'd3, r); chk("R6 flag set", r, 16'h0001);
    chk("R6 req dropped", {15'h0, dma_req}, 16'h0);
    chk("R6 dout kept", {4'h0, dout}, 16'h0060);
    chk("R9 irq masked", {15'h0, irq}, 16'h0);
    wr(2'd0, 16'h0031);
    chk("R9 irq raised", {15'h0, irq}, 16'h1);

    // R7 lockout, R8 write-one-to-clear
    pulse(0);
    chk("R7 locked load", {4'h0, dout}, 16'h0070);
    chk("R7 locked no req", {15'h0, dma_req}, 16'h0);
    wr(2'd3, 16'h0000);
    rd(2'd3, r); chk("R8 write 0 no effect", r, 16'h0001);
    wr(2'd3, 16'h0001);
    rd(2'd3, r); chk("R8 write 1 clears", r, 16'h0000);
    chk("R9 irq falls", {15'h0, irq}, 16'h0);
    pulse(0);
    chk("R7 still locked", {15'h0, dma_req}, 16'h0);
    wr(2'd0, 16'h0021);
    wr(2'd0, 16'h0031);
    pulse(0);
    chk("R7 req after re-enable", {15'h0, dma_req}, 16'h1);
    @(negedge clk); dma_ack = 1'b1;
    @(negedge clk); dma_ack = 1'b0;

    // R10 noise mode
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h004F);
    model = 12'hAAA;
    sw_fire();
    chk("R10 seed", {4'h0, dout}, {4'h0, model});
    idle(4); model = lstep(model);
    wr(2'd1, 16'h0100);
    sw_fire();
    chk("R10 one step", {4'h0, dout}, {4'h0, sat(12'h100, model)});
    idle(4); model = lstep(model);
    wr(2'd1, 16'h0F00);
    sw_fire();
    chk("R10 saturate", {4'h0, dout}, {4'h0, sat(12'hF00, model)});
    idle(4);

    // R11 reseed on disable
    wr(2'd0, 16'h004E);
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h004F);
    sw_fire();
    chk("R11 reseed", {4'h0, dout}, 16'h0AAA);

    finish_run();
  end
endmodule